// File: doc/BRIEF.md
# Serial Status Frame Receiver

This block sits on the link side of a PHY-to-link connection. It decodes the framed status messages that the PHY sends over one status wire, one bit per clock. While the line is idle it is low. A frame begins with a high start bit. The next three bits carry a message type. From that type the receiver decides how long the frame is. A short frame ends with a stop bit straight after the type. A register frame carries a 4-bit register address and 8 data bits before its stop bit.

When a frame closes with a low stop bit, the receiver updates all decoded outputs together and raises a one-cycle valid strobe. The outputs are the type, the register address and data, and one pulse flag per message kind. The two type codes that carry no message produce no strobe. A high stop bit discards the frame and raises a framing-error pulse. After that error the receiver waits for the line to go low before it looks for another start bit.

Top module: `stat_frame_rx`

## Requirements
- R1: After reset, `msg_valid_o`, `frame_err_o` and every event flag are 0, and `kind_o`, `reg_addr_o` and `reg_data_o` are 0. A line held low never produces a strobe.
- R2: A frame is a 1 start bit, then a 3-bit type sent MSB first, then a stop bit of 0. `msg_valid_o` is high for exactly one cycle: the cycle after the clock edge that samples the stop bit. A short frame loads `reg_addr_o` and `reg_data_o` with 0.
- R3: For the short types 001, 100, 101 and 110, `kind_o` shows the type while `msg_valid_o` is high. Exactly one flag pulses with the strobe: `irq_o` for 001, `restore_clean_o` for 100, `restore_reset_o` for 101, `iface_err_o` for 110.
- R4: Type 010 is a register frame. After the type come 4 address bits and then 8 data bits, each field MSB first, and then the stop bit, 17 bits in total. The strobe presents the address and data and pulses `reg_sol_o`. A 1 in the bit after the type is taken as address, not as a stop bit.
- R5: Type 011 has the same layout as type 010. It pulses `reg_unsol_o` instead of `reg_sol_o`.
- R6: Frames of type 000 or 111 that end with a good stop bit raise no strobe and no flag. They leave `kind_o`, `reg_addr_o` and `reg_data_o` unchanged.
- R7: A stop bit of 1 raises `frame_err_o` for one cycle and no strobe. The held outputs stay unchanged.
- R8: After a framing error, high bits on the line are ignored until one low bit has been seen. The first high bit after that is a new start bit.
- R9: A start bit in the cycle straight after a good stop bit begins a new frame. Both frames are reported.
- R10: `kind_o`, `reg_addr_o` and `reg_data_o` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Serial status wire, already synchronous to clk |
| msg_valid_o | output | 1 | One-cycle strobe for an accepted message |
| kind_o | output | 3 | Type of the last accepted message |
| reg_addr_o | output | ADDR_W | Register address of the last accepted message |
| reg_data_o | output | DATA_W | Register data of the last accepted message |
| irq_o | output | 1 | Interrupt message pulse |
| restore_clean_o | output | 1 | Interface restored, no bus reset, pulse |
| restore_reset_o | output | 1 | Interface restored after a bus reset, pulse |
| iface_err_o | output | 1 | Illegal request message pulse |
| reg_sol_o | output | 1 | Solicited register result pulse |
| reg_unsol_o | output | 1 | Unsolicited register result pulse |
| frame_err_o | output | 1 | Bad stop bit pulse |

## Verification
The bench sends register frames whose address starts with a 1. A receiver that fixed the frame length too early would read that bit as a bad stop bit and raise a framing error. After a framing error it holds the line high for several cycles. A receiver that resumed hunting at once would take the high bits as a new frame of type 111 and report a second error. Frames are also sent back to back, so an extra idle cycle after the stop bit would garble the second type. Reserved-type frames follow a register frame, which shows whether the held address and data get overwritten. The exact cycle of each strobe is checked, which catches an extra output register or a missing one.

// File: rtl/stat_rx_pkg.sv
package stat_rx_pkg;

  localparam int TYPE_W = 3;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_BODY  = 2'd1,
    ST_STOP  = 2'd2,
    ST_DRAIN = 2'd3
  } rx_state_e;

  localparam logic [TYPE_W-1:0] K_NONE      = 3'b000;
  localparam logic [TYPE_W-1:0] K_IRQ       = 3'b001;
  localparam logic [TYPE_W-1:0] K_REG_SOL   = 3'b010;
  localparam logic [TYPE_W-1:0] K_REG_UNSOL = 3'b011;
  localparam logic [TYPE_W-1:0] K_RST_CLEAN = 3'b100;
  localparam logic [TYPE_W-1:0] K_RST_BUS   = 3'b101;
  localparam logic [TYPE_W-1:0] K_IFERR     = 3'b110;
  localparam logic [TYPE_W-1:0] K_RSVD      = 3'b111;

  function automatic logic kind_is_reg(input logic [TYPE_W-1:0] k);
    return (k == K_REG_SOL) || (k == K_REG_UNSOL);
  endfunction

  function automatic logic kind_is_real(input logic [TYPE_W-1:0] k);
    return (k != K_NONE) && (k != K_RSVD);
  endfunction

endpackage

// File: rtl/stat_rx_shift.sv
module stat_rx_shift #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] sr_o
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) begin
      sr_d = {sr_q[W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign sr_o = sr_q;

endmodule

// File: rtl/stat_rx_ctrl.sv
module stat_rx_ctrl
  import stat_rx_pkg::*;
#(
  parameter int BODY_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [TYPE_W-1:0] type_now_i,
  output logic              shift_en_o,
  output logic              long_o,
  output logic              frame_ok_o,
  output logic              frame_bad_o
);

  localparam int CNT_W = $clog2(BODY_W + 1);
  localparam logic [CNT_W-1:0] TYPE_LAST = CNT_W'(TYPE_W - 1);
  localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(BODY_W - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             long_q, long_d;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    long_d      = long_q;
    shift_en_o  = 1'b0;
    frame_ok_o  = 1'b0;
    frame_bad_o = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (line_i) begin
          state_d = ST_BODY;
          cnt_d   = '0;
          long_d  = 1'b0;
        end
      end
      ST_BODY: begin
        shift_en_o = 1'b1;
        if (cnt_q == TYPE_LAST) begin
          long_d = kind_is_reg(type_now_i);
          if (kind_is_reg(type_now_i)) begin
            cnt_d = cnt_q + 1'b1;
          end else begin
            state_d = ST_STOP;
          end
        end else if (cnt_q == BODY_LAST) begin
          state_d = ST_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (line_i) begin
          frame_bad_o = 1'b1;
          state_d     = ST_DRAIN;
        end else begin
          frame_ok_o = 1'b1;
          state_d    = ST_HUNT;
        end
      end
      ST_DRAIN: begin
        if (!line_i) begin
          state_d = ST_HUNT;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      long_q  <= long_d;
    end
  end

  assign long_o = long_q;

endmodule

// File: rtl/stat_rx_decode.sv
module stat_rx_decode
  import stat_rx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int BODY_W = TYPE_W + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok_i,
  input  logic              frame_bad_i,
  input  logic              long_i,
  input  logic [BODY_W-1:0] sr_i,
  output logic              valid_o,
  output logic [TYPE_W-1:0] kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [5:0]        evt_o,
  output logic              err_o
);

  logic [TYPE_W-1:0] ty;
  logic              accept;
  logic              valid_d, err_d;
  logic [5:0]        evt_d;
  logic [TYPE_W-1:0] kind_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  logic              valid_q, err_q;
  logic [5:0]        evt_q;
  logic [TYPE_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // Event flag order: irq, clean, bus reset, iface err, sol, unsol.
  localparam logic [TYPE_W-1:0] EVT_KIND [6] = '{K_IRQ, K_RST_CLEAN, K_RST_BUS,
                                                 K_IFERR, K_REG_SOL, K_REG_UNSOL};

  always_comb begin
    ty     = long_i ? sr_i[BODY_W-1 -: TYPE_W] : sr_i[TYPE_W-1:0];
    accept = frame_ok_i && kind_is_real(ty);
  end

  for (genvar g = 0; g < 6; g++) begin : g_evt
    assign evt_d[g] = accept && (ty == EVT_KIND[g]);
  end

  always_comb begin
    valid_d = accept;
    err_d   = frame_bad_i;
    kind_d  = kind_q;
    addr_d  = addr_q;
    data_d  = data_q;
    if (accept) begin
      kind_d = ty;
      if (long_i) begin
        addr_d = sr_i[DATA_W +: ADDR_W];
        data_d = sr_i[DATA_W-1:0];
      end else begin
        addr_d = '0;
        data_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      evt_q   <= '0;
      kind_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      evt_q   <= evt_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign evt_o   = evt_q;
  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

endmodule

// File: rtl/stat_frame_rx.sv
module stat_frame_rx
  import stat_rx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              msg_valid_o,
  output logic [2:0]        kind_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              irq_o,
  output logic              restore_clean_o,
  output logic              restore_reset_o,
  output logic              iface_err_o,
  output logic              reg_sol_o,
  output logic              reg_unsol_o,
  output logic              frame_err_o
);

  localparam int BODY_W = TYPE_W + ADDR_W + DATA_W;

  logic [BODY_W-1:0] sr;
  logic [TYPE_W-1:0] type_now;
  logic              shift_en, is_long, frame_ok, frame_bad;
  logic [5:0]        evt;

  assign type_now = {sr[TYPE_W-2:0], line_i};

  stat_rx_shift #(.W(BODY_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_i    (line_i),
    .sr_o     (sr)
  );

  stat_rx_ctrl #(.BODY_W(BODY_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_i      (line_i),
    .type_now_i  (type_now),
    .shift_en_o  (shift_en),
    .long_o      (is_long),
    .frame_ok_o  (frame_ok),
    .frame_bad_o (frame_bad)
  );

  stat_rx_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_ok_i  (frame_ok),
    .frame_bad_i (frame_bad),
    .long_i      (is_long),
    .sr_i        (sr),
    .valid_o     (msg_valid_o),
    .kind_o      (kind_o),
    .addr_o      (reg_addr_o),
    .data_o      (reg_data_o),
    .evt_o       (evt),
    .err_o       (frame_err_o)
  );

  assign irq_o           = evt[0];
  assign restore_clean_o = evt[1];
  assign restore_reset_o = evt[2];
  assign iface_err_o     = evt[3];
  assign reg_sol_o       = evt[4];
  assign reg_unsol_o     = evt[5];

endmodule

// File: rtl/stat_frame_rx_chk.sv
module stat_frame_rx_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid_o,
  input logic [2:0]        kind_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_data_o,
  input logic              irq_o,
  input logic              restore_clean_o,
  input logic              restore_reset_o,
  input logic              iface_err_o,
  input logic              reg_sol_o,
  input logic              reg_unsol_o,
  input logic              frame_err_o
);

  logic [5:0] flags;
  assign flags = {reg_unsol_o, reg_sol_o, iface_err_o, restore_reset_o, restore_clean_o, irq_o};

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |=> !msg_valid_o);

  assert_short_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && kind_o != 3'b010 && kind_o != 3'b011) |-> (reg_addr_o == '0 && reg_data_o == '0));

  assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));

  assert_flag_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0) |-> msg_valid_o);

  assert_sol_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sol_o |-> kind_o == 3'b010);

  assert_unsol_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_unsol_o |-> kind_o == 3'b011);

  assert_no_filtered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> (kind_o != 3'b000 && kind_o != 3'b111));

  assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err_o && msg_valid_o));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid_o |-> ($stable(kind_o) && $stable(reg_addr_o) && $stable(reg_data_o)));

endmodule

bind stat_frame_rx stat_frame_rx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .msg_valid_o     (msg_valid_o),
  .kind_o          (kind_o),
  .reg_addr_o      (reg_addr_o),
  .reg_data_o      (reg_data_o),
  .irq_o           (irq_o),
  .restore_clean_o (restore_clean_o),
  .restore_reset_o (restore_reset_o),
  .iface_err_o     (iface_err_o),
  .reg_sol_o       (reg_sol_o),
  .reg_unsol_o     (reg_unsol_o),
  .frame_err_o     (frame_err_o)
);

// File: tb/stat_frame_rx_bench.sv
`timescale 1ns/1ps
module stat_frame_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_i = 1'b0;
  logic       msg_valid_o;
  logic [2:0] kind_o;
  logic [3:0] reg_addr_o;
  logic [7:0] reg_data_o;
  logic       irq_o, restore_clean_o, restore_reset_o, iface_err_o;
  logic       reg_sol_o, reg_unsol_o, frame_err_o;

  always #5 clk = ~clk;

  stat_frame_rx u_stat_frame_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .msg_valid_o(msg_valid_o), .kind_o(kind_o),
    .reg_addr_o(reg_addr_o), .reg_data_o(reg_data_o),
    .irq_o(irq_o), .restore_clean_o(restore_clean_o),
    .restore_reset_o(restore_reset_o), .iface_err_o(iface_err_o),
    .reg_sol_o(reg_sol_o), .reg_unsol_o(reg_unsol_o),
    .frame_err_o(frame_err_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: counts strobes and errors at negedge.
  int         v_cnt, e_cnt, v_cyc;
  logic [5:0] flags_seen;
  logic [2:0] last_kind;
  logic [3:0] last_addr;
  logic [7:0] last_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (msg_valid_o) begin
        v_cnt     <= v_cnt + 1;
        v_cyc     <= cyc;
        last_kind <= kind_o;
        last_addr <= reg_addr_o;
        last_data <= reg_data_o;
      end
      if (frame_err_o) e_cnt <= e_cnt + 1;
      flags_seen <= flags_seen | {reg_unsol_o, reg_sol_o, iface_err_o,
                                  restore_reset_o, restore_clean_o, irq_o};
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    v_cnt = 0; e_cnt = 0; v_cyc = -1; flags_seen = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_i = 1'b0;
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk); line_i = b;
  endtask

  // Sends one frame MSB first; returns cycle count when stop bit was driven.
  task automatic send_frame(input logic [2:0] ty, input logic [3:0] a,
                            input logic [7:0] d, input logic stopb, output int stop_cyc);
    drive_bit(1'b1);
    for (int i = 2; i >= 0; i--) drive_bit(ty[i]);
    if (ty == 3'b010 || ty == 3'b011) begin
      for (int i = 3; i >= 0; i--) drive_bit(a[i]);
      for (int i = 7; i >= 0; i--) drive_bit(d[i]);
    end
    drive_bit(stopb);
    stop_cyc = cyc;
  endtask

  function automatic logic [5:0] exp_flags(input logic [2:0] ty);
    case (ty)
      3'b001: return 6'b000001;
      3'b100: return 6'b000010;
      3'b101: return 6'b000100;
      3'b110: return 6'b001000;
      3'b010: return 6'b010000;
      3'b011: return 6'b100000;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk("R1 valid", int'(msg_valid_o), 0);
    chk("R1 kind", int'(kind_o), 0);
    chk("R1 addr", int'(reg_addr_o), 0);
    chk("R1 data", int'(reg_data_o), 0);
    chk("R1 err", int'(frame_err_o), 0);
    clear_mon();
    idle(20);
    chk("R1 idle strobes", v_cnt, 0);
  endtask

  task automatic test_short(input logic [2:0] ty);
    int sc;
    clear_mon();
    send_frame(ty, 4'h0, 8'h00, 1'b0, sc);
    idle(4);
    chk("R2 strobe count", v_cnt, 1);
    chk("R2 strobe cycle", v_cyc, sc + 1);
    chk("R2 addr zero", int'(last_addr), 0);
    chk("R3 kind", int'(last_kind), int'(ty));
    chk("R3 flag", int'(flags_seen), int'(exp_flags(ty)));
  endtask

  task automatic test_reg(input logic [2:0] ty, input logic [3:0] a, input logic [7:0] d,
                          input string req);
    int sc;
    clear_mon();
    send_frame(ty, a, d, 1'b0, sc);
    idle(4);
    chk({req, " strobe count"}, v_cnt, 1);
    chk({req, " no framing error"}, e_cnt, 0);
    chk({req, " strobe cycle"}, v_cyc, sc + 1);
    chk({req, " kind"}, int'(last_kind), int'(ty));
    chk({req, " addr"}, int'(last_addr), int'(a));
    chk({req, " data"}, int'(last_data), int'(d));
    chk({req, " flag"}, int'(flags_seen), int'(exp_flags(ty)));
  endtask

  task automatic test_filtered_r6();
    int sc;
    clear_mon();
    send_frame(3'b000, 4'h0, 8'h00, 1'b0, sc);
    idle(2);
    send_frame(3'b111, 4'h0, 8'h00, 1'b0, sc);
    idle(4);
    chk("R6 no strobe", v_cnt, 0);
    chk("R6 no flag", int'(flags_seen), 0);
    chk("R6 kind held", int'(kind_o), 3);
    chk("R6 addr held", int'(reg_addr_o), 'h9);
    chk("R6 data held", int'(reg_data_o), 'h5A);
  endtask

  task automatic test_stop_err_r7();
    int sc;
    clear_mon();
    send_frame(3'b001, 4'h0, 8'h00, 1'b1, sc);
    idle(4);
    chk("R7 err count", e_cnt, 1);
    chk("R7 no strobe", v_cnt, 0);
    chk("R7 addr held", int'(reg_addr_o), 'h9);
    chk("R10 kind held", int'(kind_o), 3);
  endtask

  task automatic test_drain_r8();
    int sc;
    clear_mon();
    send_frame(3'b100, 4'h0, 8'h00, 1'b1, sc);
    for (int i = 0; i < 5; i++) drive_bit(1'b1);
    drive_bit(1'b0);
    send_frame(3'b110, 4'h0, 8'h00, 1'b0, sc);
    idle(4);
    chk("R8 single err", e_cnt, 1);
    chk("R8 strobe after low", v_cnt, 1);
    chk("R8 kind", int'(last_kind), 6);
  endtask

  task automatic test_b2b_r9();
    int sc1, sc2;
    clear_mon();
    send_frame(3'b011, 4'hC, 8'h3E, 1'b0, sc1);
    send_frame(3'b101, 4'h0, 8'h00, 1'b0, sc2);
    idle(4);
    chk("R9 two strobes", v_cnt, 2);
    chk("R9 no err", e_cnt, 0);
    chk("R9 last kind", int'(last_kind), 5);
    chk("R9 last cycle", v_cyc, sc2 + 1);
    chk("R9 flags", int'(flags_seen), 6'b100100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_short(3'b001);
    test_short(3'b100);
    test_short(3'b101);
    test_short(3'b110);
    test_reg(3'b010, 4'hA, 8'hC3, "R4");
    test_reg(3'b011, 4'h9, 8'h5A, "R5");
    test_filtered_r6();
    test_stop_err_r7();
    test_drain_r8();
    test_b2b_r9();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule